// File: doc/BRIEF.md
# UART Receive Queue with Idle-Data Timeout

This block buffers the characters that a UART deserialiser hands over. Each stored entry keeps the character together with two per-character flags: a break flag and a combined parity/framing error flag. A consumer drains the queue through a valid/ready read port. Two interrupt lines tell the consumer when to drain. The level line is raised once the fill level reaches a programmable threshold. The idle line is raised when data has been waiting unread for a programmed number of character times.

Loss of data is reported outside the queue. A character that arrives while the queue cannot take it is discarded, and a sticky overrun status bit is set instead. Software clears that bit with a dedicated command. A second command empties the queue. A character-time tick, supplied from outside, paces the idle timer.

The write side is valid-only with an advisory `in_ready`. The deserialiser cannot be held back, so a beat offered while `in_ready` is low is dropped and counted as an overrun. The read side honours back-pressure: the head entry is consumed only in a cycle where both `out_valid` and `out_ready` are high, and `out_data` stays stable until then.

Top module: `uart_rxq_top`

## Requirements
- R1: After reset the queue is empty, `out_valid`, `level_irq`, `stale_irq` and all `status` bits are 0, and `in_ready` is 1.
- R2: Stored characters come out in arrival order. A beat accepted at a clock edge is visible at the read port in the next cycle.
- R3: `status` bit 0 is "not empty" and bit 1 is "full". Bit 5 is the error flag and bit 6 the break flag of the entry at the head; both are 0 when the queue is empty. Bits 2, 3 and 7 are always 0.
- R4: `level_irq` is 1 exactly when the fill level is nonzero and at least the threshold register. A config write with `cfg_sel`=0 sets the threshold, whose reset value is three quarters of DEPTH.
- R5: An `in_valid` beat arriving while the queue is full, and with no read in the same cycle, is discarded without changing the stored data, and it sets `status` bit 4 (overrun).
- R6: The overrun bit stays set, whatever the queue contents, until a command with `cmd_code`=3. If a new overrun falls in the same cycle as that command, the new overrun wins.
- R7: The idle timer counts `tick` pulses while the queue holds data. It restarts from zero on every stored character and whenever the queue is empty. `stale_irq` is 1 while data is pending, the timer has reached the limit, and the enable bit is set.
- R8: The idle register (written with `cfg_sel`=1) is 18 bits wide. Its limit is 16 bits: bits [4:0] of the register give limit bits [4:0], and bits [17:7] give limit bits [15:5].
- R9: Bit 5 of the idle register enables `stale_irq`. When it is 0, `stale_irq` stays 0.
- R10: The idle register resets to 0x21 (enable set, limit 1). Writing all zeros to it stores 0x21 instead.
- R11: A command with `cmd_code`=1 empties the queue and clears the idle timer. A beat offered in the same cycle is discarded and does not set overrun.
- R12: When the queue is full, a write in the same cycle as a read is stored and does not set overrun. `in_ready` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received character present this cycle |
| in_ready | output | 1 | Advisory: a beat this cycle would be stored |
| in_data | input | DW | Received character |
| in_brk | input | 1 | Character is a break |
| in_err | input | 1 | Parity or framing error on the character |
| tick | input | 1 | One-cycle pulse per character time |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: level threshold, 1: idle register |
| cfg_wdata | input | 18 | Configuration write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | 1: flush queue, 3: clear overrun, others ignored |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Consumer takes the head entry |
| out_data | output | DW | Head character |
| status | output | 8 | Status bits as in R3 and R5 |
| level_irq | output | 1 | Fill-level interrupt |
| stale_irq | output | 1 | Idle-data interrupt |

## Verification
The case of interest is a write and a read landing in the same cycle while the queue is full. The queue is filled to DEPTH. A new character is then offered in the same cycle that `out_ready` is high. The overrun bit must stay clear, `full` must remain set, and a full drain must return the seven older characters followed by the new one. A second collision is a flush command that coincides with an offered beat: the queue must come out empty, with no overrun recorded.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int STALE_W      = 18;
  localparam int LIMIT_W      = 16;
  localparam int STALE_EN_BIT = 5;
  localparam logic [STALE_W-1:0] STALE_DEFAULT = 18'h00021;

  localparam logic [3:0] CMD_FLUSH   = 4'd1;
  localparam logic [3:0] CMD_CLR_OVR = 4'd3;

  // status bit positions
  localparam int ST_NONEMPTY = 0;
  localparam int ST_FULL     = 1;
  localparam int ST_OVERRUN  = 4;
  localparam int ST_ERR      = 5;
  localparam int ST_BRK      = 6;

  // limit = {reg[17:7], reg[4:0]}
  function automatic logic [LIMIT_W-1:0] stale_limit(input logic [STALE_W-1:0] r);
    return {r[17:7], r[4:0]};
  endfunction
endpackage

// File: rtl/uart_rxq_fifo.sv
module uart_rxq_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (wr && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (wr) wp <= nxt(wp);
      if (rd) rp <= nxt(rp);
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rxq_stale.sv
module uart_rxq_stale #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic          pending,
  input  logic          enable,
  input  logic [LW-1:0] limit,
  output logic          stale
);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart || !pending)     cnt <= '0;
    else if (tick && (cnt < limit))   cnt <= cnt + 1'b1;
  end

  assign stale = enable && pending && (cnt >= limit);
endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int EW   = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_brk,
  input  logic          in_err,
  input  logic          tick,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [17:0]   cfg_wdata,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_code,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [7:0]    status,
  output logic          level_irq,
  output logic          stale_irq
);
  localparam logic [CW-1:0] WM_RESET = CW'((DEPTH * 3) / 4);

  logic              flush, clr_ovr, pop, accept, ovr_set;
  logic              empty, full;
  logic [CW-1:0]     fill;
  logic [EW-1:0]     head;
  logic [CW-1:0]     wm_q;
  logic [STALE_W-1:0] idle_q;
  logic              ovr_q;

  assign flush   = cmd_valid && (cmd_code == CMD_FLUSH);
  assign clr_ovr = cmd_valid && (cmd_code == CMD_CLR_OVR);
  assign pop     = out_ready && !empty && !flush;
  assign accept  = in_valid && (!full || pop) && !flush;
  assign ovr_set = in_valid && full && !pop && !flush;
  assign in_ready = !full || out_ready;

  uart_rxq_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr(accept), .wdata({in_brk, in_err, in_data}),
    .rd(pop), .rdata(head),
    .empty(empty), .full(full), .count(fill)
  );

  uart_rxq_stale #(.LW(LIMIT_W)) u_stale (
    .clk(clk), .rst_n(rst_n),
    .restart(flush || accept), .tick(tick),
    .pending(!empty), .enable(idle_q[STALE_EN_BIT]),
    .limit(stale_limit(idle_q)), .stale(stale_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q   <= WM_RESET;
      idle_q <= STALE_DEFAULT;
    end else if (cfg_we) begin
      if (!cfg_sel) wm_q <= cfg_wdata[CW-1:0];
      else          idle_q <= (cfg_wdata == '0) ? STALE_DEFAULT : cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ovr_set) ovr_q <= 1'b1;
    else if (clr_ovr) ovr_q <= 1'b0;
  end

  assign out_valid = !empty;
  assign out_data  = head[DW-1:0];
  assign level_irq = !empty && (fill >= wm_q);

  always_comb begin
    status              = '0;
    status[ST_NONEMPTY] = !empty;
    status[ST_FULL]     = full;
    status[ST_OVERRUN]  = ovr_q;
    status[ST_ERR]      = !empty && head[DW];
    status[ST_BRK]      = !empty && head[DW+1];
  end
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk
  import uart_rxq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] status,
  input logic       level_irq,
  input logic       stale_irq
);
  // R5: dropped beat on a full queue raises overrun
  a_r5_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && status[ST_FULL] && !out_ready && !cmd_valid) |=> status[ST_OVERRUN]);

  // R6: overrun is sticky until the clear command
  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_OVERRUN] && !(cmd_valid && cmd_code == CMD_CLR_OVR)) |=> status[ST_OVERRUN]);

  // R11: flush leaves the queue empty with no idle interrupt
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_FLUSH) |=> (!out_valid && !stale_irq));

  // R7: idle interrupt only with data pending
  a_r7_stale_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    stale_irq |-> out_valid);

  // R4: level interrupt only with data pending
  a_r4_level_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    level_irq |-> out_valid);

  // R3: head flags are clear when empty, unused bits stay 0
  a_r3_empty_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (status[6:5] == 2'b00 && status[7] == 1'b0 && status[3:2] == 2'b00));

  // R12: full queue with a read offers ready
  a_r12_ready_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_FULL] && out_ready) |-> in_ready);
endmodule

bind uart_rxq_top uart_rxq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .out_valid(out_valid),
  .out_ready(out_ready), .status(status), .level_irq(level_irq),
  .stale_irq(stale_irq)
);

// File: tb/uart_rxq_top_tb.sv
module uart_rxq_top_tb;
  localparam int DEPTH = 8;
  localparam int DW    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_brk = 0, in_err = 0, tick = 0;
  logic [DW-1:0] in_data = '0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [17:0] cfg_wdata = '0;
  logic cmd_valid = 0;
  logic [3:0] cmd_code = '0;
  logic out_ready = 0;
  logic in_ready, out_valid, level_irq, stale_irq;
  logic [DW-1:0] out_data;
  logic [7:0] status;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  uart_rxq_top #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_brk(in_brk), .in_err(in_err), .tick(tick),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .status(status),
    .level_irq(level_irq), .stale_irq(stale_irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic b, input logic e);
    in_valid = 1; in_data = d; in_brk = b; in_err = e;
    @(negedge clk);
    in_valid = 0; in_brk = 0; in_err = 0;
  endtask

  task automatic pop_expect(input logic [7:0] d, input string req);
    check(out_valid, 1, req);
    check(out_data, d, req);
    out_ready = 1; @(negedge clk); out_ready = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  task automatic cfg(input logic sel, input logic [17:0] v);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = v; @(negedge clk); cfg_we = 0;
  endtask

  task automatic cmd(input logic [3:0] c);
    cmd_valid = 1; cmd_code = c; @(negedge clk); cmd_valid = 0;
  endtask

  task automatic drain();
    out_ready = 1;
    while (out_valid) @(negedge clk);
    out_ready = 0;
  endtask

  task automatic t_reset();
    check(status, 8'h00, "R1 status");
    check(out_valid, 0, "R1 out_valid");
    check({level_irq, stale_irq}, 0, "R1 irqs");
    check(in_ready, 1, "R1 in_ready");
  endtask

  task automatic t_order();
    push(8'h41, 0, 1);
    check(status[0], 1, "R2 visible next cycle");
    push(8'h42, 1, 0);
    push(8'h43, 0, 0);
    check(status[6:5], 2'b01, "R3 head err flag");
    pop_expect(8'h41, "R2 order 1");
    check(status[6:5], 2'b10, "R3 head brk flag");
    pop_expect(8'h42, "R2 order 2");
    check(status[6:5], 2'b00, "R3 clean head");
    pop_expect(8'h43, "R2 order 3");
    check(status, 8'h00, "R3 empty status");
  endtask

  task automatic t_level();
    for (int i = 0; i < 5; i++) push(8'(i), 0, 0);
    check(level_irq, 0, "R4 below default threshold 6");
    push(8'h05, 0, 0);
    check(level_irq, 1, "R4 at default threshold 6");
    drain();
    cfg(0, 18'd2);
    push(8'h10, 0, 0);
    check(level_irq, 0, "R4 below threshold 2");
    push(8'h11, 0, 0);
    check(level_irq, 1, "R4 at threshold 2");
    drain();
    check(level_irq, 0, "R4 empty");
    cfg(0, 18'd6);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < DEPTH; i++) push(8'h20 + 8'(i), 0, 0);
    check(status[1], 1, "R3 full bit");
    check(in_ready, 0, "R5 not ready when full");
    push(8'hFF, 0, 0);
    check(status[4], 1, "R5 overrun set");
    for (int i = 0; i < DEPTH; i++) pop_expect(8'h20 + 8'(i), "R5 contents intact");
    check(out_valid, 0, "R5 dropped char absent");
    check(status[4], 1, "R6 overrun sticky when empty");
    cmd(4'd2);
    check(status[4], 1, "R6 other command ignored");
    cmd(4'd3);
    check(status[4], 0, "R6 cleared by command");
    for (int i = 0; i < DEPTH; i++) push(8'(i), 0, 0);
    in_valid = 1; in_data = 8'h99; cmd_valid = 1; cmd_code = 4'd3;
    @(negedge clk);
    in_valid = 0; cmd_valid = 0;
    check(status[4], 1, "R6 new overrun wins over clear");
    cmd(4'd3);
    drain();
  endtask

  task automatic t_stale();
    cfg(1, 18'h00023);
    push(8'h51, 0, 0);
    ticks(2);
    check(stale_irq, 0, "R7 before limit");
    push(8'h52, 0, 0);
    ticks(2);
    check(stale_irq, 0, "R7 restart on new char");
    ticks(1);
    check(stale_irq, 1, "R7 stale at limit 3");
    drain();
    check(stale_irq, 0, "R7 clears when empty");
    cfg(1, 18'h000A1);
    push(8'h53, 0, 0);
    ticks(32);
    check(stale_irq, 0, "R8 limit 33 not yet");
    ticks(1);
    check(stale_irq, 1, "R8 split limit 33");
    drain();
    cfg(1, 18'h00003);
    push(8'h54, 0, 0);
    ticks(6);
    check(stale_irq, 0, "R9 enable clear");
    drain();
    cfg(1, 18'h00000);
    push(8'h55, 0, 0);
    check(stale_irq, 0, "R10 zero write before tick");
    ticks(1);
    check(stale_irq, 1, "R10 zero write acts as limit 1");
    drain();
  endtask

  task automatic t_flush();
    cfg(1, 18'h00021);
    push(8'h61, 0, 0); push(8'h62, 0, 0);
    ticks(1);
    check(stale_irq, 1, "R11 stale before flush");
    in_valid = 1; in_data = 8'h63; cmd_valid = 1; cmd_code = 4'd1;
    @(negedge clk);
    in_valid = 0; cmd_valid = 0;
    check(out_valid, 0, "R11 queue emptied");
    check(stale_irq, 0, "R11 stale cleared");
    check(status[4], 0, "R11 no overrun on flush");
    push(8'h64, 0, 0);
    pop_expect(8'h64, "R11 works after flush");
  endtask

  task automatic t_collide();
    for (int i = 0; i < DEPTH; i++) push(8'h30 + 8'(i), 0, 0);
    out_ready = 1; in_valid = 1; in_data = 8'hEE;
    #1 check(in_ready, 1, "R12 ready with read");
    @(negedge clk);
    out_ready = 0; in_valid = 0;
    check(status[4], 0, "R12 no overrun");
    check(status[1], 1, "R12 still full");
    for (int i = 1; i < DEPTH; i++) pop_expect(8'h30 + 8'(i), "R12 older data");
    pop_expect(8'hEE, "R12 new char stored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_level();
    t_overrun();
    t_stale();
    t_flush();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule